// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Near-Full and Near-Empty Flags

This block is a parameterised first-in first-out buffer with a write port and a read port on independent clocks. Each pointer crosses into the other clock domain as Gray code through a short synchroniser chain. Full and half-full are judged on the write side and empty on the read side. Two threshold offsets drive an almost-empty flag and an almost-full flag.

The two offsets start from one of eight preset values chosen while master reset is held. Software can replace them later over a one-bit shift path or a parallel path, both clocked by the write clock. Two static settings are also sampled during master reset. One picks fall-through reads, where the head word waits on the output with no request, or strobed reads, where a word is presented only on a read request. The other picks synchronous near-flags, each moved only by its own port's clock, or split-domain near-flags, raised by one clock and cleared by the other. A partial reset empties the buffer but keeps the offsets and both settings.

Top module: `tflag_fifo`

## Requirements
- R1: After master or partial reset, and with no traffic since, emptyFlag=1, fullFlag=0, halfFlag=0, almostEmpty=1, almostFull=0 and rdData=0.
- R2: With DEPTH=16, let M be the number of words held in the storage array. fullFlag=1 exactly when M=16 and halfFlag=1 exactly when M>8. A write while full, or a read while empty, is ignored. In strobed mode an ignored read leaves rdData unchanged.
- R3: Words leave in the order they were written, with no loss and no duplication.
- R4: Once the pointers have settled, almostEmpty=1 exactly when M is at most the empty offset, and almostFull=1 exactly when 16-M is at most the full offset.
- R5: With preset index s (cfgPresetSel), both offsets reset to max(1, min(15, (s+1)*DEPTH/16)). For DEPTH=16, s=1 gives 2 and s=3 gives 4.
- R6: With loadEn=1 and serialEn=1, each write-clock edge shifts serialIn into the offsets, LSB first. The first 4 bits form the empty offset and the next 4 bits the full offset. No word is stored.
- R7: With loadEn=1, serialEn=0 and wrEn=1, wrData[3:0] is loaded into the empty offset on the first such edge after master reset and into the full offset on the next, alternating after that. These words are not stored in the buffer.
- R8: In fall-through mode (cfgFwft=1) the first word written appears on rdData with no read request, and emptyFlag=1 only when the output register holds no word. The buffer holds DEPTH+1 words, and M excludes the word in the output register.
- R9: In strobed mode (cfgFwft=0) rdData changes only on a rdClk edge with rdEn=1 while the buffer is not empty. A write alone leaves rdData unchanged.
- R10: With cfgSyncFlags=1, almostEmpty only changes on rdClk. A write that lifts M above the empty offset leaves almostEmpty at 1 for at least 1.5 write periods. With cfgSyncFlags=0, almostEmpty is raised from the read side and cleared from the write side: it falls within two write-clock edges of that write. almostFull is raised from the write side and cleared from the read side.
- R11: A partial reset clears the contents and flags but keeps the loaded offsets and the reset-chosen settings.
- R12: A master reset returns both offsets to the preset values, discarding any loaded offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| masterRstN | input | 1 | Active-low master reset; restores all settings and clears the buffer |
| partialRstN | input | 1 | Active-low partial reset; clears pointers and flags only |
| cfgFwft | input | 1 | Sampled in master reset: 1 = fall-through reads, 0 = strobed reads |
| cfgSyncFlags | input | 1 | Sampled in master reset: 1 = synchronous near-flags, 0 = split-domain near-flags |
| cfgPresetSel | input | 3 | Sampled in master reset: preset offset index |
| wrEn | input | 1 | Write request (parallel offset load when loadEn=1) |
| wrData | input | DATA_W | Write data; low bits carry a parallel offset |
| loadEn | input | 1 | Offset-load control; blocks buffer writes while high |
| serialEn | input | 1 | With loadEn, selects the one-bit shift path |
| serialIn | input | 1 | Serial offset bit |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Read data register |
| emptyFlag | output | 1 | No word available to read |
| fullFlag | output | 1 | Storage array full |
| halfFlag | output | 1 | More than half of the array in use |
| almostEmpty | output | 1 | Array count at or below the empty offset |
| almostFull | output | 1 | Free space at or below the full offset |

## Verification
The bench fills the buffer one word at a time up to the full mark and past it, then drains it past empty. After each step it checks every flag against the count, so an off-by-one threshold, a half mark on the wrong side of eight, or an overflow write that slips into the array shows up at once. It loads offsets over both load paths and then runs partial and master resets. A design that shifted bits MSB first, loaded the wrong offset first, stored offset words as data or lost offsets on partial reset would misplace a near-flag edge. In fall-through mode it checks that the head word appears unrequested and that the extra word is counted, and it times the near-empty release one write edge after a write, in both flag timing modes, to expose a flag cleared by the wrong clock.

// File: rtl/tflag_pkg.sv
package tflag_pkg;

  // Strobes from the control block to the datapath.
  typedef struct packed {
    logic memWe;    // write-clock: store wrData at wrAddr
    logic outLoad;  // read-clock: load rdData from rdAddr
  } tflagStrobe_t;

  localparam int PRESET_STEPS = 16;

  // Preset offset for index sel: scaled by depth, at least 1, below depth.
  function automatic int presetOffset(input int depth, input logic [2:0] sel);
    int v;
    v = ((int'(sel) + 1) * depth) / PRESET_STEPS;
    if (v < 1) v = 1;
    if (v > depth - 1) v = depth - 1;
    return v;
  endfunction

endpackage

// File: rtl/tflag_sync.sv
module tflag_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/tflag_xdflag.sv
// Flag raised by one clock domain and cleared by another, using a
// toggle pair so each domain owns exactly one flop of the state.
module tflag_xdflag #(
  parameter int SYNC_STAGES = 2,
  parameter bit INIT = 1'b0
) (
  input  logic setClk,
  input  logic clrClk,
  input  logic rstN,
  input  logic setCond,
  input  logic clrCond,
  output logic flagOut
);
  logic setTog, clrTog, clrTogAtSet, setTogAtClr;
  logic stateAtSet, stateAtClr;

  tflag_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clrToSet (
    .clk(setClk), .rstN(rstN), .din(clrTog), .dout(clrTogAtSet)
  );
  tflag_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(INIT)) u_setToClr (
    .clk(clrClk), .rstN(rstN), .din(setTog), .dout(setTogAtClr)
  );

  assign stateAtSet = setTog ^ clrTogAtSet;
  assign stateAtClr = setTogAtClr ^ clrTog;

  always_ff @(posedge setClk or negedge rstN) begin
    if (!rstN) setTog <= INIT;
    else if (!stateAtSet && setCond) setTog <= ~setTog;
  end

  always_ff @(posedge clrClk or negedge rstN) begin
    if (!rstN) clrTog <= 1'b0;
    else if (stateAtClr && !clrCond) clrTog <= ~clrTog;
  end

  assign flagOut = setTog ^ clrTog;
endmodule

// File: rtl/tflag_ctrl.sv
module tflag_ctrl
  import tflag_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mRstN,
  input  logic          ptrRstN,
  input  logic          cfgFwft,
  input  logic          cfgSyncFlags,
  input  logic [2:0]    cfgPresetSel,
  input  logic          wrEn,
  input  logic          loadEn,
  input  logic          serialEn,
  input  logic          serialIn,
  input  logic [AW-1:0] loadData,
  input  logic          rdEn,
  output tflagStrobe_t  strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          emptyFlag,
  output logic          fullFlag,
  output logic          halfFlag,
  output logic          almostEmpty,
  output logic          almostFull
);

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- settings latched during master reset ----------------
  logic syncW, syncR, fwftR;

  always_ff @(posedge wrClk or negedge mRstN) begin
    if (!mRstN) syncW <= cfgSyncFlags;
    else        syncW <= syncW;
  end

  always_ff @(posedge rdClk or negedge mRstN) begin
    if (!mRstN) begin
      syncR <= cfgSyncFlags;
      fwftR <= cfgFwft;
    end else begin
      syncR <= syncR;
      fwftR <= fwftR;
    end
  end

  // ---------------- offset registers (write clock) ----------------
  logic [AW-1:0]   emptyOff, fullOff;
  logic            parSel;
  logic [2*AW-1:0] offPair, offShifted;

  assign offPair    = {fullOff, emptyOff};
  assign offShifted = {serialIn, offPair[2*AW-1:1]};

  always_ff @(posedge wrClk or negedge mRstN) begin
    if (!mRstN) begin
      emptyOff <= AW'(presetOffset(DEPTH, cfgPresetSel));
      fullOff  <= AW'(presetOffset(DEPTH, cfgPresetSel));
      parSel   <= 1'b0;
    end else if (loadEn && serialEn) begin
      {fullOff, emptyOff} <= offShifted;
    end else if (loadEn && wrEn) begin
      if (!parSel) emptyOff <= loadData;
      else         fullOff  <= loadData;
      parSel <= ~parSel;
    end
  end

  // ---------------- write-side pointer ----------------
  logic [PW-1:0] wrBin, wrBinNext, wrGray, rdGrayAtW, rdBinAtW, wrCount;
  logic          wrAccept;

  tflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rdPtrToW (
    .clk(wrClk), .rstN(ptrRstN), .din(rdGray), .dout(rdGrayAtW)
  );

  assign rdBinAtW  = grayToBin(rdGrayAtW);
  assign wrCount   = wrBin - rdBinAtW;
  assign fullFlag  = (wrCount == PW'(DEPTH));
  assign halfFlag  = (wrCount > PW'(DEPTH / 2));
  assign wrAccept  = wrEn && !loadEn && !fullFlag;
  assign wrBinNext = wrBin + PW'(wrAccept);

  always_ff @(posedge wrClk or negedge ptrRstN) begin
    if (!ptrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  // ---------------- read-side pointer and output stage ----------------
  logic [PW-1:0] rdBin, rdBinNext, rdGray, wrGrayAtR, wrBinAtR, rdCount;
  logic          memEmptyR, outValid, outLoadR;

  tflag_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wrPtrToR (
    .clk(rdClk), .rstN(ptrRstN), .din(wrGray), .dout(wrGrayAtR)
  );

  assign wrBinAtR  = grayToBin(wrGrayAtR);
  assign rdCount   = wrBinAtR - rdBin;
  assign memEmptyR = (rdCount == '0);
  assign outLoadR  = fwftR ? (!memEmptyR && (!outValid || rdEn))
                           : (rdEn && !memEmptyR);
  assign rdBinNext = rdBin + PW'(outLoadR);

  always_ff @(posedge rdClk or negedge ptrRstN) begin
    if (!ptrRstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
      if (fwftR) begin
        if (outLoadR)  outValid <= 1'b1;
        else if (rdEn) outValid <= 1'b0;
      end
    end
  end

  assign emptyFlag = fwftR ? !outValid : memEmptyR;

  // ---------------- near-flag conditions from both views ----------------
  logic afCondW, afCondR, aeCondW, aeCondR, afSplit, aeSplit;

  assign afCondW = (PW'(DEPTH) - wrCount) <= {1'b0, fullOff};
  assign afCondR = (PW'(DEPTH) - rdCount) <= {1'b0, fullOff};
  assign aeCondW = wrCount <= {1'b0, emptyOff};
  assign aeCondR = rdCount <= {1'b0, emptyOff};

  // Near-full: raised by the writer, released by the reader.
  tflag_xdflag #(.SYNC_STAGES(SYNC_STAGES), .INIT(1'b0)) u_afSplit (
    .setClk(wrClk), .clrClk(rdClk), .rstN(ptrRstN),
    .setCond(afCondW), .clrCond(afCondR), .flagOut(afSplit)
  );

  // Near-empty: raised by the reader, released by the writer.
  tflag_xdflag #(.SYNC_STAGES(SYNC_STAGES), .INIT(1'b1)) u_aeSplit (
    .setClk(rdClk), .clrClk(wrClk), .rstN(ptrRstN),
    .setCond(aeCondR), .clrCond(aeCondW), .flagOut(aeSplit)
  );

  assign almostFull  = syncW ? afCondW : afSplit;
  assign almostEmpty = syncR ? aeCondR : aeSplit;

  always_comb begin
    strobe.memWe   = wrAccept;
    strobe.outLoad = outLoadR;
  end

  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = rdBin[AW-1:0];
endmodule

// File: rtl/tflag_datapath.sv
module tflag_datapath
  import tflag_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              ptrRstN,
  input  tflagStrobe_t      strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.memWe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge ptrRstN) begin
    if (!ptrRstN)            rdData <= '0;
    else if (strobe.outLoad) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/tflag_fifo.sv
module tflag_fifo
  import tflag_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRstN,
  input  logic              partialRstN,
  input  logic              cfgFwft,
  input  logic              cfgSyncFlags,
  input  logic [2:0]        cfgPresetSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadEn,
  input  logic              serialEn,
  input  logic              serialIn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              halfFlag,
  output logic              almostEmpty,
  output logic              almostFull
);
  logic          ptrRstN;
  tflagStrobe_t  strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  assign ptrRstN = masterRstN && partialRstN;

  tflag_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mRstN(masterRstN), .ptrRstN(ptrRstN),
    .cfgFwft(cfgFwft), .cfgSyncFlags(cfgSyncFlags), .cfgPresetSel(cfgPresetSel),
    .wrEn(wrEn), .loadEn(loadEn), .serialEn(serialEn), .serialIn(serialIn),
    .loadData(wrData[AW-1:0]), .rdEn(rdEn), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .emptyFlag(emptyFlag),
    .fullFlag(fullFlag), .halfFlag(halfFlag),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  tflag_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .ptrRstN(ptrRstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/tflag_fifo_chk.sv
module tflag_fifo_chk #(
  parameter int DATA_W = 9,
  parameter int AW = 4
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              masterRstN,
  input logic              partialRstN,
  input logic              loadEn,
  input logic              fullFlag,
  input logic              halfFlag,
  input logic [DATA_W-1:0] rdData,
  input logic              memWe,
  input logic              outLoad,
  input logic [AW-1:0]     wrAddr,
  input logic [AW-1:0]     rdAddr
);
  logic allRstN;
  assign allRstN = masterRstN && partialRstN;

  // R2: no array write is issued while the write side reports full
  p_full_blocks_r2: assert property (@(posedge wrClk) disable iff (!allRstN)
    fullFlag |-> !memWe);

  // R2: full implies more than half in use
  p_full_half_r2: assert property (@(posedge wrClk) disable iff (!allRstN)
    fullFlag |-> halfFlag);

  // R3: write address advances by one per stored word
  p_wr_step_r3: assert property (@(posedge wrClk) disable iff (!allRstN)
    memWe |=> (wrAddr == AW'($past(wrAddr) + 1'b1)));

  // R3: write address holds when nothing is stored
  p_wr_hold_r3: assert property (@(posedge wrClk) disable iff (!allRstN)
    !memWe |=> $stable(wrAddr));

  // R3: read address advances by one per word taken
  p_rd_step_r3: assert property (@(posedge rdClk) disable iff (!allRstN)
    outLoad |=> (rdAddr == AW'($past(rdAddr) + 1'b1)));

  // R9: the data register changes only on a load
  p_rd_hold_r9: assert property (@(posedge rdClk) disable iff (!allRstN)
    !outLoad |=> $stable(rdData));

  // R7: an offset load never writes the array
  p_load_inhibit_r7: assert property (@(posedge wrClk) disable iff (!allRstN)
    loadEn |-> !memWe);
endmodule

bind tflag_fifo tflag_fifo_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .masterRstN(masterRstN),
  .partialRstN(partialRstN), .loadEn(loadEn), .fullFlag(fullFlag),
  .halfFlag(halfFlag), .rdData(rdData), .memWe(strobe.memWe),
  .outLoad(strobe.outLoad), .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/tflag_fifo_tb.sv
`timescale 1ns/1ps
module tflag_fifo_tb;
  localparam int DW = 9;
  localparam int DEPTH = 16;

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic masterRstN = 1'b0, partialRstN = 1'b1;
  logic cfgFwft = 1'b0, cfgSyncFlags = 1'b1;
  logic [2:0] cfgPresetSel = 3'd3;
  logic wrEn = 1'b0, loadEn = 1'b0, serialEn = 1'b0, serialIn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic emptyFlag, fullFlag, halfFlag, almostEmpty, almostFull;

  int total = 0, fails = 0;
  bit done = 0;
  int q[$];
  int cap = DEPTH;
  bit fwMode = 0;

  // 250 MHz write clock (posedges at 2 mod 4); read clock posedges at 1 mod 6
  initial begin #2; forever begin wrClk = 1'b1; #2; wrClk = 1'b0; #2; end end
  initial begin #1; forever begin rdClk = 1'b1; #3; rdClk = 1'b0; #3; end end

  tflag_fifo u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .masterRstN(masterRstN), .partialRstN(partialRstN),
    .cfgFwft(cfgFwft), .cfgSyncFlags(cfgSyncFlags), .cfgPresetSel(cfgPresetSel),
    .wrEn(wrEn), .wrData(wrData), .loadEn(loadEn), .serialEn(serialEn),
    .serialIn(serialIn), .rdEn(rdEn), .rdData(rdData), .emptyFlag(emptyFlag),
    .fullFlag(fullFlag), .halfFlag(halfFlag), .almostEmpty(almostEmpty),
    .almostFull(almostFull)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int preset(input int s);
    int v;
    v = ((s + 1) * DEPTH) / 16;
    if (v < 1) v = 1;
    if (v > DEPTH - 1) v = DEPTH - 1;
    return v;
  endfunction

  task automatic settle();
    repeat (8) @(negedge rdClk);
  endtask

  task automatic checkAll(input string tag, input int e, input int f);
    int k, m;
    k = q.size();
    m = (fwMode && k > 0) ? k - 1 : k;
    chk(tag, "empty", int'(emptyFlag), int'(k == 0));
    chk(tag, "full", int'(fullFlag), int'(m == DEPTH));
    chk(tag, "half", int'(halfFlag), int'(m > DEPTH / 2));
    chk(tag, "almostEmpty", int'(almostEmpty), int'(m <= e));
    chk(tag, "almostFull", int'(almostFull), int'((DEPTH - m) <= f));
  endtask

  task automatic masterReset(input bit fw, input bit sy, input logic [2:0] sel);
    @(negedge wrClk);
    cfgFwft = fw; cfgSyncFlags = sy; cfgPresetSel = sel;
    masterRstN = 1'b0;
    #13;
    masterRstN = 1'b1;
    q.delete();
    fwMode = fw;
    cap = fw ? DEPTH + 1 : DEPTH;
    settle();
  endtask

  task automatic partialReset();
    @(negedge wrClk);
    partialRstN = 1'b0;
    #13;
    partialRstN = 1'b1;
    q.delete();
    settle();
  endtask

  task automatic doWrite(input int d);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = DW'(d);
    @(negedge wrClk);
    wrEn = 1'b0;
    if (q.size() < cap) q.push_back(d & 9'h1FF);
  endtask

  task automatic doRead();
    @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
  endtask

  task automatic fillSweep(input string tag, input int n, input int e, input int f);
    for (int i = 1; i <= n; i++) begin
      doWrite(i * 37 + 5);
      settle();
      checkAll(tag, e, f);
    end
  endtask

  initial begin
    int pair;
    int lastData;
    #20;
    masterRstN = 1'b1;
    settle();

    // R1 reset state
    checkAll("R1", 4, 4);
    chk("R1", "rdData", int'(rdData), 0);

    // R2 R4 R5 strobed-mode fill with preset 3 -> offset 4
    doWrite(300);
    settle();
    chk("R9", "rdData after write only", int'(rdData), 0);
    checkAll("R5", preset(3), preset(3));
    for (int i = 2; i <= DEPTH; i++) begin
      doWrite(i * 37 + 5);
      settle();
      checkAll("R4", preset(3), preset(3));
    end
    doWrite(9'h1AA);  // ignored: full
    settle();
    checkAll("R2", 4, 4);

    // R3 drain in order
    for (int i = 0; i < DEPTH; i++) begin
      doRead();
      settle();
      chk("R3", "rdData order", int'(rdData), q.pop_front());
      checkAll("R2", 4, 4);
    end
    lastData = int'(rdData);
    doRead();  // ignored: empty
    settle();
    chk("R2", "rdData after empty read", int'(rdData), lastData);
    chk("R2", "empty after empty read", int'(emptyFlag), 1);

    // R6 serial load: empty offset 5, full offset 3
    pair = (3 << 4) | 5;
    @(negedge wrClk);
    loadEn = 1'b1; serialEn = 1'b1;
    for (int b = 0; b < 8; b++) begin
      serialIn = pair[b];
      @(negedge wrClk);
    end
    loadEn = 1'b0; serialEn = 1'b0; serialIn = 1'b0;
    settle();
    chk("R6", "empty after serial load", int'(emptyFlag), 1);
    fillSweep("R6", DEPTH, 5, 3);

    // R11 partial reset keeps loaded offsets
    partialReset();
    checkAll("R1", 5, 3);
    fillSweep("R11", 7, 5, 3);

    // R7 parallel load: empty offset 6 then full offset 2
    partialReset();
    @(negedge wrClk);
    loadEn = 1'b1; wrEn = 1'b1; wrData = DW'(6);
    @(negedge wrClk);
    wrData = DW'(2);
    @(negedge wrClk);
    wrEn = 1'b0; loadEn = 1'b0;
    settle();
    chk("R7", "empty after parallel load", int'(emptyFlag), 1);
    fillSweep("R7", DEPTH, 6, 2);

    // R12 master reset restores presets
    masterReset(1'b0, 1'b1, 3'd3);
    checkAll("R12", 4, 4);
    fillSweep("R12", DEPTH, 4, 4);

    // R10 split-domain flags, settled in both directions
    masterReset(1'b0, 1'b0, 3'd1);
    checkAll("R1", 2, 2);
    fillSweep("R10", DEPTH, 2, 2);
    for (int i = 0; i < DEPTH; i++) begin
      doRead();
      settle();
      chk("R10", "rdData order", int'(rdData), q.pop_front());
      checkAll("R10", 2, 2);
    end
    // R10 split-domain near-empty released by the write clock
    doWrite(11); doWrite(12);
    settle();
    chk("R10", "split AE before", int'(almostEmpty), 1);
    doWrite(13);
    @(negedge wrClk);
    chk("R10", "split AE fast release", int'(almostEmpty), 0);

    // R10 synchronous near-empty only moves on the read clock
    masterReset(1'b0, 1'b1, 3'd1);
    doWrite(21); doWrite(22);
    settle();
    chk("R10", "sync AE before", int'(almostEmpty), 1);
    doWrite(23);
    @(negedge wrClk);
    chk("R10", "sync AE still set", int'(almostEmpty), 1);
    settle();
    chk("R10", "sync AE released", int'(almostEmpty), 0);

    // R8 fall-through mode, preset 0 -> offset 1
    masterReset(1'b1, 1'b1, 3'd0);
    checkAll("R1", 1, 1);
    doWrite(77);
    settle();
    chk("R8", "head visible without read", int'(rdData), 77);
    checkAll("R8", 1, 1);
    for (int i = 2; i <= DEPTH + 1; i++) begin
      doWrite(i * 37 + 5);
      settle();
      checkAll("R8", 1, 1);
    end
    doWrite(9'h155);  // ignored: full
    settle();
    checkAll("R8", 1, 1);
    for (int i = 0; i < DEPTH + 1; i++) begin
      chk("R8", "head data", int'(rdData), q[0]);
      doRead();
      void'(q.pop_front());
      settle();
      checkAll("R8", 1, 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule